// File: doc/BRIEF.md
# Timer Output Pulse and Clock Shaper

This block turns the period-match strobe of one timer half into the level driven on a timer output pin. In pulse mode every match produces a high pulse whose length is set by a small width field. In clock mode every match flips the output, so the pin carries a square wave at half the match rate. A polarity bit inverts the pin without changing the internal level, and a status output carries that internal level so software can read it.

All state advances only on cycles where the timer clock enable is high. A run input tells the block whether its timer half is running. While the half is held, the output returns to its inactive level and any pulse in progress is dropped. The counter that produces the match strobe lives outside this block.

Top module: `tmr_out_shaper`

## Requirements
- R1: While `rst_n` is low, `level_status` is 0 and `pin_out` equals `out_invert`.
- R2: In pulse mode (`clk_mode` = 0), a `match` sampled on a clock edge with `tick_en` = 1 and `half_run` = 1 sets the level high from that edge on. The level stays high for `pulse_width` + 1 timer ticks: code 0 gives 1 tick, 1 gives 2, 2 gives 3 and 3 gives 4.
- R3: In pulse mode, a `match` that arrives while a pulse is high reloads the width count, so the pulse ends `pulse_width` + 1 ticks after the last match.
- R4: In clock mode (`clk_mode` = 1), every qualified `match` inverts the level, and the level holds between matches.
- R5: `pin_out` equals the level when `out_invert` = 0 and its complement when `out_invert` = 1.
- R6: `level_status` equals the level before inversion, whatever the value of `out_invert`.
- R7: While `half_run` is 0, the level goes low on the next edge and any pulse in progress is cancelled, even if `match` is high in that same cycle. After `half_run` returns to 1, the level stays low until a new match.
- R8: On cycles with `tick_en` = 0, the block ignores `match` and freezes the level and any remaining pulse length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_run | input | 1 | 1 while the owning timer half runs; 0 holds the output inactive |
| tick_en | input | 1 | Timer clock enable; state advances only when high |
| match | input | 1 | Period-match strobe from the counter |
| clk_mode | input | 1 | 0 = pulse mode, 1 = clock (toggle) mode |
| pulse_width | input | PW_BITS (2) | Pulse length code; the length is the code + 1 ticks |
| out_invert | input | 1 | 1 inverts the driven pin |
| pin_out | output | 1 | Timer output pin |
| level_status | output | 1 | Output level before inversion |

## Verification
Two pairs of events can land in the same cycle. In the first, a new match arrives while a pulse is still high. The bench raises `match` one tick after a pulse starts and checks that the high time grows to one tick plus the full programmed length. In the second, a hold and a match arrive together. The bench raises `half_run` low in the same cycle as `match`, in both modes, and checks that the level reads low on the next sample: the hold wins. The bench also gates `tick_en` low while `match` is high, and checks that both a pulse in flight and the idle state stay frozen.

// File: rtl/tos_pkg.sv
package tos_pkg;
  // default bit count of the pulse length code
  localparam int PW_BITS_DEF = 2;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_CLOCK = 1'b1
  } out_mode_e;
endpackage

// File: rtl/tos_pulse_gen.sv
module tos_pulse_gen #(
  parameter int PW_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               fire,
  input  logic [PW_BITS-1:0] width_code,
  output logic               level
);
  logic [PW_BITS-1:0] remain_q, remain_d;
  logic               level_q, level_d;

  always_comb begin
    remain_d = remain_q;
    level_d  = level_q;
    if (!run) begin
      remain_d = '0;
      level_d  = 1'b0;
    end else if (tick) begin
      if (fire) begin
        level_d  = 1'b1;
        remain_d = width_code;
      end else if (level_q) begin
        if (remain_q == '0) level_d = 1'b0;
        else                remain_d = remain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      level_q  <= 1'b0;
    end else begin
      remain_q <= remain_d;
      level_q  <= level_d;
    end
  end

  assign level = level_q;

  // R2
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && fire) |=> (level_q && remain_q == $past(width_code)));

  // R2
  remain_implies_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q != '0) |-> level_q);

  // R7
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!level_q && remain_q == '0));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(level_q) && $stable(remain_q)));
endmodule

// File: rtl/tos_toggle_gen.sv
module tos_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic fire,
  output logic level
);
  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (!run)              level_d = 1'b0;
    else if (tick && fire) level_d = ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign level = level_q;

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && fire) |=> (level_q != $past(level_q)));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && fire)) |=> $stable(level_q));

  // R7
  toggle_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !level_q);
endmodule

// File: rtl/tos_out_stage.sv
module tos_out_stage (
  input  logic            clk,
  input  logic            rst_n,
  input  tos_pkg::out_mode_e mode,
  input  logic            pulse_level,
  input  logic            toggle_level,
  input  logic            invert,
  output logic            pin,
  output logic            status
);
  logic raw;

  always_comb begin
    raw = (mode == tos_pkg::MODE_CLOCK) ? toggle_level : pulse_level;
  end

  assign pin    = raw ^ invert;
  assign status = raw;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!status && pin == invert));
endmodule

// File: rtl/tmr_out_shaper.sv
module tmr_out_shaper #(
  parameter int PW_BITS = tos_pkg::PW_BITS_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_run,
  input  logic               tick_en,
  input  logic               match,
  input  logic               clk_mode,
  input  logic [PW_BITS-1:0] pulse_width,
  input  logic               out_invert,
  output logic               pin_out,
  output logic               level_status
);
  tos_pkg::out_mode_e mode;
  logic               pulse_fire, toggle_fire;
  logic               pulse_lvl, toggle_lvl;

  assign mode        = tos_pkg::out_mode_e'(clk_mode);
  assign pulse_fire  = match && (mode == tos_pkg::MODE_PULSE);
  assign toggle_fire = match && (mode == tos_pkg::MODE_CLOCK);

  tos_pulse_gen #(.PW_BITS(PW_BITS)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (half_run),
    .tick       (tick_en),
    .fire       (pulse_fire),
    .width_code (pulse_width),
    .level      (pulse_lvl)
  );

  tos_toggle_gen u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (half_run),
    .tick  (tick_en),
    .fire  (toggle_fire),
    .level (toggle_lvl)
  );

  tos_out_stage u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .pulse_level  (pulse_lvl),
    .toggle_level (toggle_lvl),
    .invert       (out_invert),
    .pin          (pin_out),
    .status       (level_status)
  );

  // R7
  top_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_run |=> !level_status);
endmodule

// File: tb/tmr_out_shaper_test.sv
module tmr_out_shaper_test;
  logic       clk = 1'b0;
  logic       rst_n, half_run, tick_en, match, clk_mode, out_invert;
  logic [1:0] pulse_width;
  logic       pin_out, level_status;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tmr_out_shaper uut (
    .clk(clk), .rst_n(rst_n), .half_run(half_run), .tick_en(tick_en),
    .match(match), .clk_mode(clk_mode), .pulse_width(pulse_width),
    .out_invert(out_invert), .pin_out(pin_out), .level_status(level_status)
  );

  // entries: {width code[5:4], invert[3], expected high ticks[2:0]}
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 1'b0, 3'd1}, {2'd1, 1'b0, 3'd2}, {2'd2, 1'b0, 3'd3}, {2'd3, 1'b0, 3'd4},
    {2'd3, 1'b1, 3'd4}, {2'd2, 1'b1, 3'd3}, {2'd1, 1'b1, 3'd2}, {2'd0, 1'b1, 3'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fire one match at this negedge, then count high samples of level_status
  task automatic pulse_run(output int len, output int pol_bad);
    len = 0;
    pol_bad = 0;
    match = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      match = 1'b0;
      if (level_status) len++;
      if (pin_out != (level_status ^ out_invert)) pol_bad++;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, bad;
    rst_n = 1'b0; half_run = 1'b1; tick_en = 1'b1; match = 1'b0;
    clk_mode = 1'b0; out_invert = 1'b1; pulse_width = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status in reset", level_status, 0);
    chk("R1 pin in reset", pin_out, 1);
    out_invert = 1'b0;
    #1 chk("R1 pin follows invert in reset", pin_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R6 vector table: pulse lengths and polarity
    foreach (VEC[k]) begin
      pulse_width = VEC[k][5:4];
      out_invert  = VEC[k][3];
      pulse_run(len, bad);
      chk($sformatf("R2 pulse length vec %0d", k), len, int'(VEC[k][2:0]));
      chk($sformatf("R5 R6 polarity vec %0d", k), bad, 0);
    end

    // R5 R6 idle level with inversion
    out_invert = 1'b1;
    #1;
    chk("R6 idle status with invert", level_status, 0);
    chk("R5 idle pin with invert", pin_out, 1);
    out_invert = 1'b0;

    // R3 retrigger during pulse: 1 + 2 ticks high for width code 1
    pulse_width = 2'd1;
    match = 1'b1;
    @(negedge clk);
    chk("R3 first pulse high", level_status, 1);
    len = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      match = 1'b0;
      if (level_status) len++;
    end
    chk("R3 retriggered length", len, 3);

    // R8 match ignored without tick
    tick_en = 1'b0; match = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 match ignored while tick low", level_status, 0);
    // R8 pulse frozen while tick low
    pulse_width = 2'd0; tick_en = 1'b1;
    @(negedge clk);
    match = 1'b0; tick_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 pulse frozen high", level_status, 1);
    tick_en = 1'b1;
    @(negedge clk);
    chk("R8 pulse ends after tick resumes", level_status, 0);

    // R7 hold cancels pulse
    pulse_width = 2'd3; match = 1'b1;
    @(negedge clk);
    match = 1'b0;
    chk("R7 pulse started", level_status, 1);
    half_run = 1'b0;
    @(negedge clk);
    chk("R7 hold drops level", level_status, 0);
    half_run = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 stays low after release", level_status, 0);
    // R7 hold wins over coincident match
    half_run = 1'b0; match = 1'b1;
    @(negedge clk);
    chk("R7 hold beats match pulse mode", level_status, 0);
    half_run = 1'b1; match = 1'b0;
    @(negedge clk);

    // R4 clock mode toggling
    clk_mode = 1'b1;
    for (int m = 0; m < 4; m++) begin
      match = 1'b1;
      @(negedge clk);
      match = 1'b0;
      chk($sformatf("R4 toggle after match %0d", m), level_status, (m % 2 == 0) ? 1 : 0);
      repeat (2) @(negedge clk);
      chk($sformatf("R4 holds between matches %0d", m), level_status, (m % 2 == 0) ? 1 : 0);
    end
    // R5 in clock mode with inversion
    out_invert = 1'b1; match = 1'b1;
    @(negedge clk);
    match = 1'b0;
    chk("R6 clock mode status", level_status, 1);
    chk("R5 clock mode pin inverted", pin_out, 0);
    // R7 hold with coincident match in clock mode
    half_run = 1'b0; match = 1'b1;
    @(negedge clk);
    chk("R7 hold beats match clock mode", level_status, 0);
    chk("R5 pin at inactive inverted", pin_out, 1);
    half_run = 1'b1; match = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule